// File: doc/BRIEF.md
# Receive Destination Address Filter

The filter looks at the destination address at the head of each received Ethernet frame and decides whether the frame is kept or dropped. The receive datapath feeds the first six bytes of every frame into a byte input. A start marker flags the first byte. One clock after the sixth byte arrives, the block raises a single-cycle decision strobe that carries an accept flag.

Three mechanisms can accept a frame. The first is a 16-entry exact-match table, where entry 0 normally holds the station address and the other entries hold multicast groups. Each entry carries its own valid flag. The second is a 4096-bit multicast bitmap. It is indexed directly by twelve raw address bits, so no CRC is computed. The third is a set of promiscuous control bits. Broadcast frames are governed by a dedicated bit only.

Software configures the block through a word-wide write port. A write that lands while an address is being received is held back, so it only affects the frames that follow.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `dec_valid` is low, the control word is zero, every table entry is invalid and every bitmap bit is clear, so every frame is rejected.
- R2: While control bit 1 (enable) is 0, every decided frame is rejected, whatever the table, bitmap and other control bits hold.
- R3: Table entry e uses word address 2e and word address 2e+1. The low word holds address bytes 3..0 as {b3,b2,b1,b0}. The high word holds {b5,b4} in bits 15:0 and the valid flag in bit 31. A non-broadcast frame whose address equals a valid entry is accepted. An entry with valid 0 never matches.
- R4: For a multicast address (bit 0 of byte 0 set), the bitmap index is {b5[3:0], b4}. The index selects bit index[4:0] of the bitmap word at word address 0x80 + index[11:5]. A set bit accepts the frame. Bits 7:4 of byte 5 do not take part. Unicast addresses never consult the bitmap.
- R5: Control bit 3 accepts every unicast (non-multicast) address.
- R6: Control bit 4 accepts every multicast address other than broadcast.
- R7: The all-ones address is accepted exactly when control bit 15 and the enable bit are both set. Table entries, bitmap bits and bit 4 have no effect on it.
- R8: `dec_valid` is high for exactly one cycle, in the cycle after the clock edge that samples the sixth address byte. Byte positions are counted from the last byte marked with `in_sof`, and cycles with `in_valid` low are skipped. Bytes after the sixth produce no further decision. A new `in_sof` before the sixth byte restarts the address.
- R9: A write that arrives from the cycle of the start byte through the cycle of the sixth byte does not affect that frame's decision. It does affect every later frame.
- R10: While control bit 0 (receive reset) is set, input bytes are ignored and no decision is issued. Once the bit is cleared, only a byte marked `in_sof` begins a new address.
- R11: The control word sits at word address 0x20. Writes to word addresses 0x21 through 0x7F change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Word address of the write |
| wr_data | input | 32 | Write data |
| in_valid | input | 1 | An address byte is present on `in_byte` |
| in_sof | input | 1 | The present byte is byte 0 of a frame |
| in_byte | input | 8 | Received byte |
| dec_valid | output | 1 | Single-cycle decision strobe |
| dec_accept | output | 1 | Accept (1) or reject (0), meaningful with `dec_valid` |

## Verification
The assertions check several rules on every cycle. The decision strobe always follows the sixth byte by one clock and never lasts two cycles. A disabled filter, or a broadcast whose gate is closed, always yields a reject. Receive reset suppresses decisions. The deferred-write backlog never overflows and is always empty by the time a decision is made. Unmapped writes leave the control word and table untouched. Only the bench scenarios can show the decision semantics themselves: that a particular table entry or bitmap bit accepts the address it should, that invalid entries and the upper nibble of byte 5 are ignored, and that a write made mid-address takes effect exactly one frame later.

// File: rtl/rdf_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the receive destination address filter.
package rdf_pkg;
    localparam int MAC_W   = 48;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int MAC_BYTES = MAC_W / BYTE_W;

    // Control word bit positions.
    localparam int CTL_RXRST = 0;
    localparam int CTL_EN    = 1;
    localparam int CTL_ALLU  = 3;
    localparam int CTL_ALLM  = 4;
    localparam int CTL_BCAST = 15;

    // High-word valid flag position of a table entry.
    localparam int ENT_VLD_BIT = 31;

    // One exact-match table entry: address as {b5,b4,b3,b2,b1,b0}.
    typedef struct packed {
        logic             vld;
        logic [MAC_W-1:0] mac;
    } ent_t;
endpackage

// File: rtl/rdf_wr_queue.sv
`timescale 1ns/1ps
// rdf_wr_queue: small FIFO holding configuration writes deferred while an
// address is being received.
// Assumes DEPTH is a power of two (pointers wrap naturally) and that the
// owner never pushes into a full queue without popping in the same cycle.
module rdf_wr_queue #(
    parameter int W     = 40,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    // Storage write; contents need no reset because the count guards reads.
    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign dout  = mem[rp_q];
    assign count = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rdf_cfg_store.sv
`timescale 1ns/1ps
// rdf_cfg_store: holds the exact-match table, the control word and the
// multicast bitmap, and applies one configuration write per cycle.
// Word map: 0..2N-1 table (even = low word, odd = high word), 2N control,
// upper half of the address space = bitmap words; everything else ignored.
// Assumes 2*N_ENT+1 <= bitmap word count so the regions do not overlap.
module rdf_cfg_store
    import rdf_pkg::*;
#(
    parameter int N_ENT     = 16,
    parameter int HASH_BITS = 12,
    parameter int AW        = HASH_BITS - 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ap_en,
    input  logic [AW-1:0]          ap_addr,
    input  logic [WORD_W-1:0]      ap_data,
    input  logic [HASH_BITS-1:0]   map_idx,
    output logic                   map_bit,
    output ent_t [N_ENT-1:0]       tbl,
    output logic [WORD_W-1:0]      ctrl
);
    localparam int MAP_WORDS = (1 << HASH_BITS) / WORD_W;
    localparam int MW_W      = $clog2(MAP_WORDS);
    localparam int IDX_W     = $clog2(N_ENT);
    localparam int TBL_WORDS = 2 * N_ENT;
    localparam int CTRL_ADDR = TBL_WORDS;

    logic [WORD_W-1:0] map_q [MAP_WORDS];
    logic              hit_tbl, hit_ctl, hit_map;
    logic [IDX_W-1:0]  ent_sel;
    logic [MW_W-1:0]   word_sel;

    // Decode which region the write address falls in.
    always_comb begin
        hit_tbl  = ap_addr < AW'(TBL_WORDS);
        hit_ctl  = ap_addr == AW'(CTRL_ADDR);
        hit_map  = ap_addr[AW-1];
        ent_sel  = ap_addr[IDX_W:1];
        word_sel = ap_addr[MW_W-1:0];
    end

    // Table entries: low word sets bytes 3..0, high word sets bytes 5..4 and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N_ENT; e++) tbl[e] <= '0;
        end else if (ap_en && hit_tbl) begin
            if (ap_addr[0]) begin
                tbl[ent_sel].vld                <= ap_data[ENT_VLD_BIT];
                tbl[ent_sel].mac[MAC_W-1:WORD_W] <= ap_data[MAC_W-WORD_W-1:0];
            end else begin
                tbl[ent_sel].mac[WORD_W-1:0]     <= ap_data;
            end
        end
    end

    // Control word.
    always_ff @(posedge clk) begin
        if (!rst_n)                ctrl <= '0;
        else if (ap_en && hit_ctl) ctrl <= ap_data;
    end

    // Multicast bitmap words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < MAP_WORDS; w++) map_q[w] <= '0;
        end else if (ap_en && hit_map) begin
            map_q[word_sel] <= ap_data;
        end
    end

    // Bitmap lookup by the raw address index.
    assign map_bit = map_q[map_idx[HASH_BITS-1:5]][map_idx[4:0]];

    // R11
    unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_en && !hit_tbl && !hit_ctl && !hit_map) |=> ($stable(ctrl) && $stable(tbl)));
endmodule

// File: rtl/rdf_addr_collect.sv
`timescale 1ns/1ps
// rdf_addr_collect: gathers the six destination bytes of a frame.
// A byte with in_sof starts a new address; the sixth byte raises `fire`
// combinationally with the full address on `addr`. Later bytes are ignored.
// While rx_hold is set nothing is captured and no address is in progress.
module rdf_addr_collect
    import rdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_hold,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              sof_take,
    output logic              fire,
    output logic              busy,
    output logic [MAC_W-1:0]  addr
);
    localparam int LAST  = MAC_BYTES - 1;
    localparam int CNT_W = $clog2(MAC_BYTES);

    logic [CNT_W-1:0]         cnt_q;
    logic                     step;
    logic [LAST*BYTE_W-1:0]   held;

    // Qualify the incoming byte.
    always_comb begin
        sof_take = in_valid && in_sof && !rx_hold;
        step     = in_valid && busy && !in_sof && !rx_hold;
        fire     = step && (cnt_q == CNT_W'(LAST));
    end

    // One holding register per early address byte.
    for (genvar k = 0; k < LAST; k++) begin : g_byte
        logic [BYTE_W-1:0] q;
        logic              cap;
        assign cap = (k == 0) ? sof_take : (step && cnt_q == CNT_W'(k));
        // Capture byte k when it arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (cap) q <= in_byte;
        end
        assign held[k*BYTE_W +: BYTE_W] = q;
    end

    // Track whether an address is in progress and which byte comes next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (rx_hold) begin
            busy  <= 1'b0;
        end else if (sof_take) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(1);
        end else if (step) begin
            if (cnt_q == CNT_W'(LAST)) busy <= 1'b0;
            else                       cnt_q <= cnt_q + 1'b1;
        end
    end

    assign addr = {in_byte, held};

    // R8
    fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/rdf_decide.sv
`timescale 1ns/1ps
// rdf_decide: turns a completed destination address into an accept/reject
// decision and registers it for one cycle.
// Assumes the table, bitmap and control inputs are stable for the frame.
module rdf_decide
    import rdf_pkg::*;
#(
    parameter int N_ENT     = 16,
    parameter int HASH_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [MAC_W-1:0]      addr,
    input  ent_t [N_ENT-1:0]      tbl,
    input  logic [WORD_W-1:0]     ctrl,
    input  logic                  map_bit,
    output logic [HASH_BITS-1:0]  map_idx,
    output logic                  dec_valid,
    output logic                  dec_accept
);
    logic [N_ENT-1:0] hit;
    logic             is_mc, is_bc, accept_c;

    // One comparator per table entry.
    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        assign hit[e] = tbl[e].vld && (tbl[e].mac == addr);
    end

    // Raw index: byte 4 plus the low bits of byte 5.
    assign map_idx = addr[4*BYTE_W +: HASH_BITS];

    // Combine the match sources under the control bits.
    always_comb begin
        is_mc = addr[0];
        is_bc = &addr;
        if (!ctrl[CTL_EN])  accept_c = 1'b0;
        else if (is_bc)     accept_c = ctrl[CTL_BCAST];
        else                accept_c = (|hit)
                                    || (is_mc && map_bit)
                                    || (!is_mc && ctrl[CTL_ALLU])
                                    || (is_mc && ctrl[CTL_ALLM]);
    end

    // Register the decision strobe and its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= fire;
            dec_accept <= fire && accept_c;
        end
    end

    // R2
    disabled_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ctrl[CTL_EN]) |=> (dec_valid && !dec_accept));
    // R7
    bcast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (&addr) && !ctrl[CTL_BCAST]) |=> !dec_accept);
    // R8
    valid_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> dec_valid);
    // R8
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !dec_valid);
endmodule

// File: rtl/rx_dest_filter.sv
`timescale 1ns/1ps
// rx_dest_filter: receive destination address filter.
// Collects the six destination bytes, looks them up in an exact-match table
// and a raw-bit multicast bitmap, applies the control bits, and reports one
// decision a clock after the sixth byte. Writes made while an address is in
// reception are queued and applied afterwards. Assumes the backlog left by
// one frame is at most five writes when the next frame's bytes arrive
// back to back, so the queue drains before the next decision.
module rx_dest_filter
    import rdf_pkg::*;
#(
    parameter int N_ENT     = 16,
    parameter int HASH_BITS = 12,
    parameter int WQ_DEPTH  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [HASH_BITS-5:0]   wr_addr,
    input  logic [31:0]            wr_data,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic [7:0]             in_byte,
    output logic                   dec_valid,
    output logic                   dec_accept
);
    localparam int AW = HASH_BITS - 4;
    localparam int QW = AW + WORD_W;
    localparam int CW = $clog2(WQ_DEPTH + 1);

    ent_t [N_ENT-1:0]      tbl;
    logic [WORD_W-1:0]     ctrl;
    logic [HASH_BITS-1:0]  map_idx;
    logic                  map_bit;
    logic                  sof_take, fire, busy;
    logic [MAC_W-1:0]      addr;
    logic                  recv_now, direct, push, pop;
    logic [QW-1:0]         q_dout;
    logic                  q_empty, q_full;
    logic [CW-1:0]         q_cnt, old_cnt;
    logic                  ap_en;
    logic [AW-1:0]         ap_addr;
    logic [WORD_W-1:0]     ap_data;

    rdf_addr_collect u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_hold  (ctrl[CTL_RXRST]),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_byte  (in_byte),
        .sof_take (sof_take),
        .fire     (fire),
        .busy     (busy),
        .addr     (addr)
    );

    // Route writes: straight through when idle, queued during reception.
    always_comb begin
        recv_now = busy || sof_take;
        direct   = wr_en && !recv_now && q_empty;
        push     = wr_en && !direct;
        pop      = !q_empty && (!busy || old_cnt != '0);
        ap_en    = pop || direct;
        ap_addr  = pop ? q_dout[QW-1:WORD_W]  : wr_addr;
        ap_data  = pop ? q_dout[WORD_W-1:0]   : wr_data;
    end

    rdf_wr_queue #(.W(QW), .DEPTH(WQ_DEPTH)) u_wq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({wr_addr, wr_data}),
        .pop   (pop),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full),
        .count (q_cnt)
    );

    // Count queued writes that predate the address now in reception.
    always_ff @(posedge clk) begin
        if (!rst_n)                      old_cnt <= '0;
        else if (sof_take)               old_cnt <= q_cnt - CW'(pop);
        else if (pop && old_cnt != '0)   old_cnt <= old_cnt - 1'b1;
    end

    rdf_cfg_store #(.N_ENT(N_ENT), .HASH_BITS(HASH_BITS), .AW(AW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .ap_en   (ap_en),
        .ap_addr (ap_addr),
        .ap_data (ap_data),
        .map_idx (map_idx),
        .map_bit (map_bit),
        .tbl     (tbl),
        .ctrl    (ctrl)
    );

    rdf_decide #(.N_ENT(N_ENT), .HASH_BITS(HASH_BITS)) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .addr       (addr),
        .tbl        (tbl),
        .ctrl       (ctrl),
        .map_bit    (map_bit),
        .map_idx    (map_idx),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );

    // R9
    backlog_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (old_cnt == '0));
    // R10
    hold_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[CTL_RXRST] |=> !dec_valid);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !dec_valid);
endmodule

// File: tb/rx_dest_filter_bench.sv
`timescale 1ns/1ps
module rx_dest_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        dec_valid, dec_accept;

    int  n_tot = 0;
    int  n_bad = 0;
    bit  started = 0;
    bit  finished = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    rx_dest_filter u_rx_dest_filter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .in_valid(in_valid), .in_sof(in_sof),
        .in_byte(in_byte), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_lo [16];
    logic [15:0] m_hi [16];
    logic        m_vld [16];
    logic [31:0] m_ctrl;
    logic [31:0] m_map [128];
    logic [7:0]  m_b [6];
    int          m_cnt;
    bit          m_busy, m_ev, m_ea;
    logic [39:0] pend [$];

    task automatic m_apply(input logic [7:0] a, input logic [31:0] d);
        if (a < 8'd32) begin
            if (a[0]) begin m_vld[a >> 1] = d[31]; m_hi[a >> 1] = d[15:0]; end
            else m_lo[a >> 1] = d;
        end else if (a == 8'd32) m_ctrl = d;
        else if (a >= 8'd128) m_map[a - 8'd128] = d;
    endtask

    function automatic bit m_decide();
        logic [47:0] mac;
        logic [11:0] idx;
        bit ex;
        mac = {m_b[5], m_b[4], m_b[3], m_b[2], m_b[1], m_b[0]};
        idx = {m_b[5][3:0], m_b[4]};
        ex = 0;
        for (int e = 0; e < 16; e++)
            if (m_vld[e] && {m_hi[e], m_lo[e]} == mac) ex = 1;
        if (!m_ctrl[1]) return 0;
        if (mac == 48'hFFFF_FFFF_FFFF) return m_ctrl[15];
        if (ex) return 1;
        if (mac[0]) return m_map[idx / 32][idx % 32] || m_ctrl[4];
        return m_ctrl[3];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < 16; e++) begin m_lo[e] = 0; m_hi[e] = 0; m_vld[e] = 0; end
            for (int w = 0; w < 128; w++) m_map[w] = 0;
            m_ctrl = 0; m_busy = 0; m_cnt = 0; m_ev = 0; m_ea = 0;
            pend.delete();
        end else begin
            bit hold, sof_t, rcv;
            m_ev = 0;
            hold  = m_ctrl[0];
            sof_t = in_valid && in_sof && !hold;
            rcv   = m_busy || sof_t;
            if (hold) m_busy = 0;
            else if (in_valid) begin
                if (in_sof) begin m_b[0] = in_byte; m_cnt = 1; m_busy = 1; end
                else if (m_busy) begin
                    m_b[m_cnt] = in_byte;
                    m_cnt++;
                    if (m_cnt == 6) begin m_ev = 1; m_ea = m_decide(); m_busy = 0; end
                end
            end
            if (wr_en) begin
                if (rcv) pend.push_back({wr_addr, wr_data});
                else m_apply(wr_addr, wr_data);
            end
            if (m_ev) while (pend.size() > 0) begin
                logic [39:0] p;
                p = pend.pop_front();
                m_apply(p[39:32], p[31:0]);
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Per-cycle comparison against the model (R8 timing, accept under cur_req).
    always @(negedge clk) begin
        if (started && rst_n && !finished) begin
            chk(dec_valid === m_ev, "R8 strobe vs model", dec_valid, m_ev);
            if (m_ev && dec_valid)
                chk(dec_accept === m_ea, cur_req, dec_accept, m_ea);
        end
    end

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Send one address; exp: 1 accept, 0 reject, -1 no decision expected.
    task automatic send(input logic [47:0] mac, input int expv, input string req,
                        input int wr_at, input logic [7:0] wa, input logic [31:0] wd,
                        input int gap_at, input int trail);
        logic gv, ga;
        cur_req = req;
        for (int i = 0; i < 6; i++) begin
            if (i == gap_at) begin in_valid = 0; @(negedge clk); end
            in_valid = 1; in_sof = (i == 0); in_byte = mac[8*i +: 8];
            if (i == wr_at) begin wr_en = 1; wr_addr = wa; wr_data = wd; end
            @(negedge clk);
            wr_en = 0; in_sof = 0;
        end
        gv = dec_valid; ga = dec_accept;
        for (int t = 0; t < trail; t++) begin
            in_valid = 1; in_byte = 8'hA0 + 8'(t);
            @(negedge clk);
        end
        in_valid = 0;
        repeat (6) @(negedge clk);
        if (expv < 0) chk(gv == 0, req, gv, 0);
        else begin
            chk(gv == 1, req, gv, 1);
            chk(ga == expv[0], req, ga, expv);
        end
    endtask

    task automatic fr(input logic [47:0] mac, input int expv, input string req);
        send(mac, expv, req, -1, 8'h0, 32'h0, -1, 0);
    endtask

    logic [47:0] own, unk, mc_t, mc_h, bc;

    initial begin
        own  = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        unk  = mk(8'h02, 8'h99, 8'h88, 8'h77, 8'h66, 8'h55);
        mc_t = mk(8'h01, 8'h00, 8'h5e, 8'h7f, 8'h00, 8'h01);
        mc_h = mk(8'h01, 8'h00, 8'h5e, 8'h00, 8'hab, 8'hc3);
        bc   = 48'hFFFF_FFFF_FFFF;
        repeat (4) @(negedge clk);
        rst_n = 1;
        started = 1;
        chk(dec_valid == 0, "R1 strobe low after reset", dec_valid, 0);
        fr(bc,  0, "R1 reset rejects broadcast");
        fr(own, 0, "R1 reset rejects unicast");

        // R3: exact-match table
        wr(8'h20, 32'h2);
        fr(own, 0, "R3 no entry");
        wr(8'h00, 32'h3322_1102); wr(8'h01, 32'h8000_5544);
        fr(own, 1, "R3 entry 0 match");
        wr(8'h0A, 32'hccbb_aa02); wr(8'h0B, 32'h0000_eedd);
        fr(mk(8'h02, 8'haa, 8'hbb, 8'hcc, 8'hdd, 8'hee), 0, "R3 invalid entry");
        wr(8'h0B, 32'h8000_eedd);
        fr(mk(8'h02, 8'haa, 8'hbb, 8'hcc, 8'hdd, 8'hee), 1, "R3 entry 5 valid");
        wr(8'h1E, 32'h7f5e_0001); wr(8'h1F, 32'h8000_0100);
        fr(mc_t, 1, "R3 entry 15 multicast");

        // R4: bitmap, index 0x3AB -> word 29 bit 11
        fr(mc_h, 0, "R4 bit clear");
        wr(8'h9D, 32'h0000_0800);
        fr(mc_h, 1, "R4 bit set");
        fr(mk(8'h01, 8'h00, 8'h5e, 8'h00, 8'hab, 8'hf3), 1, "R4 byte5 high nibble ignored");
        fr(mk(8'h02, 8'h00, 8'h5e, 8'h00, 8'hab, 8'hc3), 0, "R4 unicast skips bitmap");
        fr(mk(8'h01, 8'h00, 8'h5e, 8'h00, 8'hac, 8'hc3), 0, "R4 neighbour bit");

        // R5 / R6
        wr(8'h20, 32'hA);
        fr(unk, 1, "R5 all unicast");
        fr(mk(8'h01, 8'h00, 8'h5e, 8'h11, 8'h22, 8'h03), 0, "R5 multicast not covered");
        wr(8'h20, 32'h12);
        fr(mk(8'h01, 8'h00, 8'h5e, 8'h11, 8'h22, 8'h03), 1, "R6 all multicast");
        fr(unk, 0, "R6 unicast not covered");

        // R7: broadcast gate
        fr(bc, 0, "R7 all multicast does not admit broadcast");
        wr(8'h0E, 32'hFFFF_FFFF); wr(8'h0F, 32'h8000_FFFF); wr(8'hFF, 32'h8000_0000);
        fr(bc, 0, "R7 table and bitmap do not admit broadcast");
        wr(8'h20, 32'h8002);
        fr(bc, 1, "R7 broadcast bit");

        // R2: enable clear
        wr(8'h20, 32'h8018);
        fr(own, 0, "R2 disabled table hit");
        fr(bc,  0, "R2 disabled broadcast");
        fr(unk, 0, "R2 disabled all unicast");

        // R8: timing, trailing bytes, gaps, restart
        wr(8'h20, 32'h2);
        send(own, 1, "R8 trailing bytes", -1, 8'h0, 32'h0, -1, 12);
        send(own, 1, "R8 gap inside address", -1, 8'h0, 32'h0, 3, 0);
        cur_req = "R8 restart";
        for (int i = 0; i < 3; i++) begin
            in_valid = 1; in_sof = (i == 0); in_byte = own[8*i +: 8];
            @(negedge clk);
            chk(dec_valid == 0, "R8 no decision on partial address", dec_valid, 0);
        end
        send(unk, 0, "R8 restart by new start byte", -1, 8'h0, 32'h0, -1, 0);

        // R9: writes during reception
        wr(8'h06, 32'hbead_de02);
        send(mk(8'h02, 8'hde, 8'had, 8'hbe, 8'hef, 8'h01), 0, "R9 entry write deferred",
             3, 8'h07, 32'h8000_01ef, -1, 0);
        fr(mk(8'h02, 8'hde, 8'had, 8'hbe, 8'hef, 8'h01), 1, "R9 entry write applied");
        send(unk, 0, "R9 control write deferred", 1, 8'h20, 32'hA, -1, 0);
        fr(unk, 1, "R9 control write applied");
        send(own, 1, "R9 write in start cycle deferred", 0, 8'h20, 32'h0, -1, 0);
        fr(own, 0, "R9 disable applied next frame");
        send(own, 0, "R9 write in last byte cycle deferred", 5, 8'h20, 32'h2, -1, 0);
        fr(own, 1, "R9 enable applied next frame");

        // R10: receive reset
        wr(8'h20, 32'h3);
        fr(own, -1, "R10 held receiver silent");
        wr(8'h20, 32'h2);
        cur_req = "R10 no start byte";
        for (int i = 0; i < 6; i++) begin
            in_valid = 1; in_sof = 0; in_byte = own[8*i +: 8];
            @(negedge clk);
        end
        in_valid = 0;
        @(negedge clk);
        chk(dec_valid == 0, "R10 bytes without start ignored", dec_valid, 0);
        repeat (4) @(negedge clk);
        fr(own, 1, "R10 receiver resumes");

        // R11: unmapped addresses
        wr(8'h21, 32'hFFFF_FFFF); wr(8'h50, 32'hFFFF_FFFF); wr(8'h7F, 32'hFFFF_FFFF);
        fr(unk, 0, "R11 unmapped writes leave control");
        fr(bc,  0, "R11 unmapped writes leave broadcast gate");
        fr(own, 1, "R11 unmapped writes leave table");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            n_tot++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end
endmodule